// File: doc/BRIEF.md
# Queued SPI Interrupt and Error Controller

This block is the status and interrupt logic that sits beside a queued SPI transfer engine. It watches three kinds of event. The first is a queue command finishing. The second is a CPU write into the queue memory entry whose command is executing. The third is software clearing the SPI run-enable bit while a transfer is in progress. Each event has a sticky flag that software clears by writing one, and each flag has its own interrupt enable. The single interrupt output is the level OR of the enabled flags.

The block also owns the SPI run-enable bit. Software can set or clear this bit through the control-register write port, and the engine clears it when the queue finishes. Two configuration bits can turn a write collision or an abort attempt into a bus access error, reported as a pulse in the cycle of the offending write. A lock-out bit stops software from clearing the run-enable bit at all, so that only the engine can stop a transfer.

The queue memory holds 48 entries that software reaches through an address/data register pair. Entries 0 to 15 hold transmit words, entries 16 to 31 hold receive words, and entries 32 to 47 hold command bytes. The serial shifter, the baud generator and the memory itself are outside this block and appear only as event inputs.

Top module: `qspi_irq_ctrl`

## Requirements
- R1: After synchronous reset, `reg_rdata`, `spi_en`, `irq` and `bus_err` are all zero.
- R2: The status register has the following layout, and every other bit reads 0 and ignores writes.
  - Bit 0: finished flag. Bit 1: abort flag. Bit 2: collision flag.
  - Bits 4, 5, 6: the interrupt enables of those three flags, in that order (read/write).
  - Bit 8: collision error enable. Bit 9: abort error enable. Bit 10: abort lock-out (all read/write).
- R3: A pulse on `eng_cmd_done` with `eng_cmd_ptr == eng_end_ptr` sets the finished flag at the next edge. Outside wraparound mode it also clears `spi_en`. A command completing at any other pointer, with no halt request, sets nothing.
- R4: A pulse on `eng_cmd_done` while `eng_halt_req` is high sets the finished flag and clears `spi_en`, whatever the pointer.
- R5: With `eng_wrap` high, each end-pointer completion sets the finished flag again, and `spi_en` stays set.
- R6: Writing 1 to a flag bit clears that flag. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when some flag and its enable are both set. It follows the registered flags, so it rises one cycle after the event and stays high until the flag is cleared.
- R8: If an event sets a flag in the same cycle that software writes 1 to clear that flag, the flag ends up set.
- R9: A queue memory write with `eng_busy` high, to address 2*CMD_DEPTH + `eng_cmd_ptr`, sets the collision flag. Writes to other addresses, or writes while idle, do not.
- R10: When the collision error enable is set, a colliding write drives `bus_err` high in that same cycle. When it is clear, `bus_err` stays low.
- R11: A control write with `ctl_wr_val` = 0, while `spi_en` and `eng_busy` are both high, clears `spi_en` and sets the abort flag. The same write while idle clears `spi_en` and sets no flag.
- R12: When the abort error enable is set, such an abort attempt drives `bus_err` high in the same cycle. This happens even when lock-out is set.
- R13: With lock-out set, a control write of 0 leaves `spi_en` set and raises no abort flag. The engine can still clear `spi_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | CPU write strobe for the status register |
| reg_wdata | input | 16 | Write data for the status register |
| reg_rdata | output | 16 | Status register read value |
| ctl_wr_en | input | 1 | CPU write strobe for the run-enable bit |
| ctl_wr_val | input | 1 | Value written to the run-enable bit |
| qram_wr_en | input | 1 | CPU write strobe into queue memory via the data register |
| qram_wr_addr | input | 6 | Queue memory entry addressed by that write |
| eng_busy | input | 1 | Engine is executing a transfer |
| eng_cmd_done | input | 1 | One-cycle pulse: current command completed |
| eng_cmd_ptr | input | 4 | Index of the command being executed |
| eng_end_ptr | input | 4 | Index of the last command of the queue |
| eng_halt_req | input | 1 | Halt requested at the end of the current command |
| eng_wrap | input | 1 | Wraparound mode |
| spi_en | output | 1 | SPI run-enable bit |
| irq | output | 1 | Level interrupt request |
| bus_err | output | 1 | Access-error pulse, aligned with the offending write |

## Verification
The bound checker watches several rules on every cycle. It checks that reserved bits stay zero and that `irq` matches the enabled flags. It checks that end-pointer and halt completions set the finished flag, and that a completion wins over a same-cycle clear. It also covers collision detection, the lock-out of software clears, and that `bus_err` only appears alongside a CPU write. Other behaviour can only be shown by the bench's directed scenarios. These include the negative cases, such as completions at other pointers, writes to the transmit and receive regions, and idle clears that raise no abort. They also include the contrast between wraparound and single-pass runs, and the masking of a set flag by its enable.

// File: rtl/qspi_irq_pkg.sv
package qspi_irq_pkg;

    localparam int REG_W    = 16;
    localparam int NFLAG    = 3;
    localparam int FLAG_LSB = 0;
    localparam int IE_LSB   = 4;
    localparam int CFG_LSB  = 8;
    localparam int NCFG     = 3;

    typedef enum logic [1:0] {
        FLG_DONE = 2'd0,
        FLG_ABRT = 2'd1,
        FLG_COLL = 2'd2
    } flag_idx_e;

    typedef struct packed {
        logic abrt_lock;
        logic abrt_err_en;
        logic coll_err_en;
    } cfg_t;

    function automatic logic [REG_W-1:0] field_mask(input int lsb, input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < n; i++) m[lsb+i] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] RW_MASK =
        field_mask(FLAG_LSB, NFLAG) | field_mask(IE_LSB, NFLAG) | field_mask(CFG_LSB, NCFG);

endpackage

// File: rtl/qspi_evt_detect.sv
module qspi_evt_detect
    import qspi_irq_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    localparam int PTR_W    = $clog2(CMD_DEPTH),
    localparam int ADDR_W   = $clog2(3*CMD_DEPTH)
) (
    input  logic              eng_busy,
    input  logic              eng_cmd_done,
    input  logic [PTR_W-1:0]  eng_cmd_ptr,
    input  logic [PTR_W-1:0]  eng_end_ptr,
    input  logic              eng_halt_req,
    input  logic              eng_wrap,
    input  logic              qram_wr_en,
    input  logic [ADDR_W-1:0] qram_wr_addr,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_val,
    input  logic              spi_en,
    input  cfg_t              cfg,
    output logic [NFLAG-1:0]  evt_set,
    output logic              hw_stop,
    output logic              bus_err
);
    localparam int CMD_BASE = 2*CMD_DEPTH;

    logic [ADDR_W-1:0] live_cmd_addr;
    logic              at_end, coll_hit, abrt_try;

    always_comb begin
        live_cmd_addr = ADDR_W'(CMD_BASE) + ADDR_W'(eng_cmd_ptr);
        at_end        = (eng_cmd_ptr == eng_end_ptr);
        coll_hit      = qram_wr_en & eng_busy & (qram_wr_addr == live_cmd_addr);
        abrt_try      = ctl_wr_en & ~ctl_wr_val & spi_en & eng_busy;
        hw_stop       = eng_cmd_done & (eng_halt_req | (at_end & ~eng_wrap));

        evt_set           = '0;
        evt_set[FLG_DONE] = eng_cmd_done & (at_end | eng_halt_req);
        evt_set[FLG_ABRT] = abrt_try & ~cfg.abrt_lock;
        evt_set[FLG_COLL] = coll_hit;

        bus_err = (coll_hit & cfg.coll_err_en) | (abrt_try & cfg.abrt_err_en);
    end

endmodule

// File: rtl/qspi_flag_bank.sv
module qspi_flag_bank
    import qspi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic [NFLAG-1:0] evt_set,
    output logic [NFLAG-1:0] flags,
    output logic [NFLAG-1:0] ie,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rdata
);
    logic unused_rsv_bits;
    assign unused_rsv_bits = ^(wdata & ~RW_MASK);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic clr;
        assign clr = wr_en & wdata[FLAG_LSB+g];
        always_ff @(posedge clk) begin
            if (rst)               flags[g] <= 1'b0;
            else if (evt_set[g])   flags[g] <= 1'b1;
            else if (clr)          flags[g] <= 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst)        ie[g] <= 1'b0;
            else if (wr_en) ie[g] <= wdata[IE_LSB+g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        cfg <= '0;
        else if (wr_en) cfg <= cfg_t'(wdata[CFG_LSB +: NCFG]);
    end

    always_comb begin
        rdata                    = '0;
        rdata[FLAG_LSB +: NFLAG] = flags;
        rdata[IE_LSB +: NFLAG]   = ie;
        rdata[CFG_LSB +: NCFG]   = cfg;
    end

endmodule

// File: rtl/qspi_run_ctl.sv
module qspi_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ctl_wr_en,
    input  logic ctl_wr_val,
    input  logic lock,
    input  logic hw_stop,
    output logic spi_en
);
    logic sw_ok;
    assign sw_ok = ctl_wr_en & (ctl_wr_val | ~lock);

    always_ff @(posedge clk) begin
        if (rst)          spi_en <= 1'b0;
        else if (hw_stop) spi_en <= 1'b0;
        else if (sw_ok)   spi_en <= ctl_wr_val;
    end

endmodule

// File: rtl/qspi_irq_ctrl.sv
module qspi_irq_ctrl
    import qspi_irq_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    localparam int PTR_W    = $clog2(CMD_DEPTH),
    localparam int ADDR_W   = $clog2(3*CMD_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_val,
    input  logic              qram_wr_en,
    input  logic [ADDR_W-1:0] qram_wr_addr,
    input  logic              eng_busy,
    input  logic              eng_cmd_done,
    input  logic [PTR_W-1:0]  eng_cmd_ptr,
    input  logic [PTR_W-1:0]  eng_end_ptr,
    input  logic              eng_halt_req,
    input  logic              eng_wrap,
    output logic              spi_en,
    output logic              irq,
    output logic              bus_err
);
    logic [NFLAG-1:0] evt_set, flags, ie;
    cfg_t             cfg;
    logic             hw_stop;

    qspi_evt_detect #(.CMD_DEPTH(CMD_DEPTH)) u_evt (
        .eng_busy     (eng_busy),
        .eng_cmd_done (eng_cmd_done),
        .eng_cmd_ptr  (eng_cmd_ptr),
        .eng_end_ptr  (eng_end_ptr),
        .eng_halt_req (eng_halt_req),
        .eng_wrap     (eng_wrap),
        .qram_wr_en   (qram_wr_en),
        .qram_wr_addr (qram_wr_addr),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_val   (ctl_wr_val),
        .spi_en       (spi_en),
        .cfg          (cfg),
        .evt_set      (evt_set),
        .hw_stop      (hw_stop),
        .bus_err      (bus_err)
    );

    qspi_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wdata   (reg_wdata),
        .evt_set (evt_set),
        .flags   (flags),
        .ie      (ie),
        .cfg     (cfg),
        .rdata   (reg_rdata)
    );

    qspi_run_ctl u_run (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr_en  (ctl_wr_en),
        .ctl_wr_val (ctl_wr_val),
        .lock       (cfg.abrt_lock),
        .hw_stop    (hw_stop),
        .spi_en     (spi_en)
    );

    assign irq = |(flags & ie);

endmodule

// File: rtl/qspi_irq_ctrl_chk.sv
module qspi_irq_ctrl_chk
    import qspi_irq_pkg::*;
#(
    parameter int CMD_DEPTH = 16,
    localparam int PTR_W    = $clog2(CMD_DEPTH),
    localparam int ADDR_W   = $clog2(3*CMD_DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              ctl_wr_en,
    input logic              ctl_wr_val,
    input logic              qram_wr_en,
    input logic [ADDR_W-1:0] qram_wr_addr,
    input logic              eng_busy,
    input logic              eng_cmd_done,
    input logic [PTR_W-1:0]  eng_cmd_ptr,
    input logic [PTR_W-1:0]  eng_end_ptr,
    input logic              eng_halt_req,
    input logic              eng_wrap,
    input logic              spi_en,
    input logic              irq,
    input logic              bus_err
);
    logic [ADDR_W-1:0] chk_cmd_addr;
    logic              chk_stop, chk_abort;
    assign chk_cmd_addr = ADDR_W'(2*CMD_DEPTH) + ADDR_W'(eng_cmd_ptr);
    assign chk_stop     = eng_cmd_done &&
                          (eng_halt_req || (eng_cmd_ptr == eng_end_ptr && !eng_wrap));
    assign chk_abort    = ctl_wr_en && !ctl_wr_val && spi_en && eng_busy && !reg_rdata[10];

    assert_rsv_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~RW_MASK) == '0);

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq == |(reg_rdata[2:0] & reg_rdata[6:4]));

    assert_end_sets_R3: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_done && eng_cmd_ptr == eng_end_ptr |=> reg_rdata[0]);

    assert_halt_stops_R4: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_done && eng_halt_req |=> reg_rdata[0] && !spi_en);

    assert_wrap_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        spi_en && eng_wrap && eng_cmd_done && !eng_halt_req && !ctl_wr_en |=> spi_en);

    assert_w1c_abort_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en && reg_wdata[1] && !chk_abort |=> !reg_rdata[1]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        eng_cmd_done && eng_halt_req && reg_wr_en && reg_wdata[0] |=> reg_rdata[0]);

    assert_coll_flag_R9: assert property (@(posedge clk) disable iff (rst)
        qram_wr_en && eng_busy && qram_wr_addr == chk_cmd_addr |=> reg_rdata[2]);

    assert_berr_source_R10: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (qram_wr_en && eng_busy) || (ctl_wr_en && !ctl_wr_val));

    assert_lockout_R13: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[10] && spi_en && ctl_wr_en && !ctl_wr_val && !chk_stop |=> spi_en);

endmodule

bind qspi_irq_ctrl qspi_irq_ctrl_chk #(.CMD_DEPTH(CMD_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_wr_en(ctl_wr_en), .ctl_wr_val(ctl_wr_val),
    .qram_wr_en(qram_wr_en), .qram_wr_addr(qram_wr_addr), .eng_busy(eng_busy),
    .eng_cmd_done(eng_cmd_done), .eng_cmd_ptr(eng_cmd_ptr), .eng_end_ptr(eng_end_ptr),
    .eng_halt_req(eng_halt_req), .eng_wrap(eng_wrap), .spi_en(spi_en), .irq(irq),
    .bus_err(bus_err)
);

// File: tb/tb_qspi_irq_ctrl.sv
module tb_qspi_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ctl_wr_en = 1'b0;
    logic        ctl_wr_val = 1'b0;
    logic        qram_wr_en = 1'b0;
    logic [5:0]  qram_wr_addr = '0;
    logic        eng_busy = 1'b0;
    logic        eng_cmd_done = 1'b0;
    logic [3:0]  eng_cmd_ptr = '0;
    logic [3:0]  eng_end_ptr = 4'd7;
    logic        eng_halt_req = 1'b0;
    logic        eng_wrap = 1'b0;
    logic        spi_en, irq, bus_err;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    logic berr_seen;

    always #4 clk = ~clk;

    qspi_irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ctl_wr_en(ctl_wr_en), .ctl_wr_val(ctl_wr_val),
        .qram_wr_en(qram_wr_en), .qram_wr_addr(qram_wr_addr), .eng_busy(eng_busy),
        .eng_cmd_done(eng_cmd_done), .eng_cmd_ptr(eng_cmd_ptr), .eng_end_ptr(eng_end_ptr),
        .eng_halt_req(eng_halt_req), .eng_wrap(eng_wrap), .spi_en(spi_en), .irq(irq),
        .bus_err(bus_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [15:0] v);
        reg_wr_en = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic ctl_wr(input logic v);
        ctl_wr_en = 1'b1; ctl_wr_val = v;
        #1 berr_seen = bus_err;
        @(negedge clk);
        ctl_wr_en = 1'b0; ctl_wr_val = 1'b0;
    endtask

    task automatic qram_wr(input logic [5:0] a);
        qram_wr_en = 1'b1; qram_wr_addr = a;
        #1 berr_seen = bus_err;
        @(negedge clk);
        qram_wr_en = 1'b0; qram_wr_addr = '0;
    endtask

    task automatic cmd_done(input logic [3:0] p, input logic halt);
        eng_cmd_ptr = p; eng_cmd_done = 1'b1; eng_halt_req = halt;
        @(negedge clk);
        eng_cmd_done = 1'b0; eng_halt_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rdata", reg_rdata, 16'h0000);
        chk("R1", "spi_en", {15'd0, spi_en}, 16'd0);
        chk("R1", "irq", {15'd0, irq}, 16'd0);
        chk("R1", "bus_err", {15'd0, bus_err}, 16'd0);
    endtask

    task automatic t_layout();
        reg_wr(16'hFFFF);
        chk("R2", "all-ones write", reg_rdata, 16'h0770);
        reg_wr(16'h0070);
        chk("R2", "enables only", reg_rdata, 16'h0070);
    endtask

    task automatic t_end_ptr();
        ctl_wr(1'b1);
        chk("R3", "spi_en started", {15'd0, spi_en}, 16'd1);
        eng_busy = 1'b1;
        cmd_done(4'd4, 1'b0);
        chk("R3", "mid-queue no flag", reg_rdata, 16'h0070);
        chk("R3", "mid-queue still running", {15'd0, spi_en}, 16'd1);
        cmd_done(4'd7, 1'b0);
        chk("R3", "end flag", reg_rdata, 16'h0071);
        chk("R3", "end stops", {15'd0, spi_en}, 16'd0);
        chk("R7", "irq on finish", {15'd0, irq}, 16'd1);
        reg_wr(16'h0071);
        chk("R7", "irq after clear", {15'd0, irq}, 16'd0);
        eng_busy = 1'b0;
    endtask

    task automatic t_halt();
        ctl_wr(1'b1);
        eng_busy = 1'b1;
        cmd_done(4'd2, 1'b1);
        chk("R4", "halt flag", reg_rdata, 16'h0071);
        chk("R4", "halt stops", {15'd0, spi_en}, 16'd0);
        reg_wr(16'h0071);
        eng_busy = 1'b0;
    endtask

    task automatic t_wrap();
        ctl_wr(1'b1);
        eng_busy = 1'b1; eng_wrap = 1'b1;
        cmd_done(4'd7, 1'b0);
        chk("R5", "wrap pass 1 flag", reg_rdata, 16'h0071);
        chk("R5", "wrap keeps running", {15'd0, spi_en}, 16'd1);
        reg_wr(16'h0071);
        chk("R6", "cleared between passes", reg_rdata, 16'h0070);
        cmd_done(4'd7, 1'b0);
        chk("R5", "wrap pass 2 flag", reg_rdata, 16'h0071);
        chk("R5", "wrap pass 2 running", {15'd0, spi_en}, 16'd1);
        eng_wrap = 1'b0; eng_busy = 1'b0;
        ctl_wr(1'b0);
        chk("R11", "idle clear stops", {15'd0, spi_en}, 16'd0);
        chk("R11", "idle clear no abort", reg_rdata, 16'h0071);
        reg_wr(16'h0071);
    endtask

    task automatic t_w1c();
        cmd_done(4'd7, 1'b0);
        reg_wr(16'h0070);
        chk("R6", "write 0 keeps flag", reg_rdata, 16'h0071);
        reg_wr(16'h0071);
        chk("R6", "write 1 clears", reg_rdata, 16'h0070);
    endtask

    task automatic t_race();
        eng_cmd_ptr = 4'd7; eng_cmd_done = 1'b1;
        reg_wr_en = 1'b1; reg_wdata = 16'h0071;
        @(negedge clk);
        eng_cmd_done = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
        chk("R8", "set beats clear", reg_rdata, 16'h0071);
        reg_wr(16'h0071);
    endtask

    task automatic t_mask();
        cmd_done(4'd7, 1'b0);
        reg_wr(16'h0060);
        chk("R7", "masked flag held", reg_rdata, 16'h0061);
        chk("R7", "masked irq low", {15'd0, irq}, 16'd0);
        reg_wr(16'h0071);
        chk("R7", "restore", reg_rdata, 16'h0070);
    endtask

    task automatic t_collision();
        eng_busy = 1'b1; eng_cmd_ptr = 4'd3;
        qram_wr(6'd3);
        chk("R9", "tx region no flag", reg_rdata, 16'h0070);
        qram_wr(6'd19);
        chk("R9", "rx region no flag", reg_rdata, 16'h0070);
        qram_wr(6'd35);
        chk("R10", "no berr when disabled", {15'd0, berr_seen}, 16'd0);
        chk("R9", "collision flag", reg_rdata, 16'h0074);
        chk("R7", "collision irq", {15'd0, irq}, 16'd1);
        reg_wr(16'h0174);
        chk("R6", "collision cleared", reg_rdata, 16'h0170);
        qram_wr(6'd36);
        chk("R10", "other cmd no berr", {15'd0, berr_seen}, 16'd0);
        chk("R9", "other cmd no flag", reg_rdata, 16'h0170);
        qram_wr(6'd35);
        chk("R10", "berr on collision", {15'd0, berr_seen}, 16'd1);
        chk("R9", "collision flag again", reg_rdata, 16'h0174);
        reg_wr(16'h0174);
        eng_busy = 1'b0;
        qram_wr(6'd35);
        chk("R9", "idle no flag", reg_rdata, 16'h0170);
        chk("R10", "idle no berr", {15'd0, berr_seen}, 16'd0);
    endtask

    task automatic t_abort();
        reg_wr(16'h0270);
        ctl_wr(1'b1);
        eng_busy = 1'b1;
        ctl_wr(1'b0);
        chk("R12", "abort berr", {15'd0, berr_seen}, 16'd1);
        chk("R11", "abort flag", reg_rdata, 16'h0272);
        chk("R11", "abort stops", {15'd0, spi_en}, 16'd0);
        reg_wr(16'h0072);
        ctl_wr(1'b1);
        ctl_wr(1'b0);
        chk("R12", "no berr when disabled", {15'd0, berr_seen}, 16'd0);
        chk("R11", "abort flag 2", reg_rdata, 16'h0072);
        reg_wr(16'h0072);
        eng_busy = 1'b0;
    endtask

    task automatic t_lock();
        reg_wr(16'h0670);
        eng_busy = 1'b1;
        ctl_wr(1'b1);
        ctl_wr(1'b0);
        chk("R12", "locked attempt berr", {15'd0, berr_seen}, 16'd1);
        chk("R13", "locked keeps running", {15'd0, spi_en}, 16'd1);
        chk("R13", "locked no abort", reg_rdata, 16'h0670);
        cmd_done(4'd7, 1'b0);
        chk("R13", "engine still stops", {15'd0, spi_en}, 16'd0);
        chk("R3", "finish under lock", reg_rdata, 16'h0671);
        eng_busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_layout();
        t_end_ptr();
        t_halt();
        t_wrap();
        t_w1c();
        t_race();
        t_mask();
        t_collision();
        t_abort();
        t_lock();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule